// File: doc/BRIEF.md
# Serial FIFO Flag and Interrupt Controller

This block runs beside a UART-style serial port whose transmit and receive FIFOs live elsewhere. It mirrors the fill level of each FIFO from its push and pop strobes. It compares each level with a threshold chosen by a 2-bit trigger field. From these comparisons and from the receiver's error, break, overrun and idle events it keeps six status flags.

Software reads the flags over a small register bus. It clears a flag by writing 0 to it after it has read that flag as 1. The two threshold flags are level-sensitive, so a flag that is cleared while its FIFO still meets the threshold comes back on the next cycle.

The flags drive four interrupt lines, each gated by its own enable bit. A priority-encoded source number names the most urgent line. Only the two data-moving conditions, receive data and transmit space, also raise DMA requests.

Top module: `sfifo_flag_ctrl`

## Requirements
- R1: Each level counter starts at 0 and holds 0 to 16. A push is accepted when the count is below 16 and a pop when it is above 0, both judged on the count before the edge. Accepted strobes change the count at the same edge, so a push and a pop together leave it unchanged unless one of them is rejected. The count register at `reg_sel`=2 returns the transmit count in bits 15:8 and the receive count in bits 7:0.
- R2: Status bit 0 (transmit space) becomes 1 one cycle after the transmit count is at or below the transmit trigger. Control bits 1:0 select the trigger as 0→8, 1→4, 2→2, 3→1. The flag stays 1 if the count later rises.
- R3: Status bit 1 (receive fill) becomes 1 one cycle after the receive count is at or above the receive trigger. Control bits 3:2 select the trigger as 0→1, 1→4, 2→8, 3→14.
- R4: The status register sits at `reg_sel`=0 with bit 0 transmit space, 1 receive fill, 2 data ready, 3 receive error, 4 break and 5 overrun. A write clears a flag only where the written bit is 0 and the flag has been read as 1 (a read with `reg_rd`) since it last cleared. Writing 1, or writing 0 without such a read, has no effect.
- R5: If a threshold flag is cleared while its threshold condition still holds, it reads 0 for one cycle and 1 again on the next.
- R6: A pulse on `rx_err_evt`, `rx_brk_evt` or `rx_ovr_evt` sets status bit 3, 4 or 5 at the next edge. `rx_idle_evt` sets bit 2 only while the receive count is nonzero. For these four event flags, an event in the same cycle as a clearing write wins.
- R7: With control bits 4, 5, 6 and 7 as the enables, the lines behave as follows. `irq_err` is bit 3 AND enable 4. `irq_rxd` is (bit 1 OR bit 2) AND enable 5. `irq_bo` is (bit 4 OR bit 5) AND enable 6. `irq_tx` is bit 0 AND enable 7. All four are valid in the same cycle as the flags and the control register.
- R8: `dma_rx_req` equals `irq_rxd` and `dma_tx_req` equals `irq_tx`. The error and break/overrun conditions never raise a DMA request.
- R9: `irq_src` reports the highest asserted line as 1 for error, 2 for receive data, 3 for break/overrun and 4 for transmit, and 0 when none is asserted. The priority order is error, receive data, break/overrun, transmit.
- R10: While `rst_n` is low at a clock edge, the counts, flags and control register become 0, so every interrupt, DMA and source output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_push | input | 1 | Byte written into the transmit FIFO |
| tx_pop | input | 1 | Byte taken from the transmit FIFO by the shifter |
| rx_push | input | 1 | Byte stored into the receive FIFO |
| rx_pop | input | 1 | Byte read from the receive FIFO |
| rx_err_evt | input | 1 | Receive error event pulse |
| rx_brk_evt | input | 1 | Break detected pulse |
| rx_ovr_evt | input | 1 | Receive overrun pulse |
| rx_idle_evt | input | 1 | Receive line idle timeout pulse |
| reg_sel | input | 2 | Register select: 0 status, 1 control, 2 count |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms clearing) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| irq_err | output | 1 | Receive error interrupt |
| irq_rxd | output | 1 | Receive data interrupt |
| irq_bo | output | 1 | Break/overrun interrupt |
| irq_tx | output | 1 | Transmit space interrupt |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| irq_src | output | 3 | Highest pending interrupt source |

## Verification
Strobes are driven at the falling edge. A count therefore changes at the next rising edge and is sampled at the falling edge after it. A threshold or event flag needs one more rising edge, so the bench waits an extra cycle before reading it. A clearing write shows its 0 at the falling edge right after the write edge, and a re-asserting threshold flag is checked one cycle later. Interrupt, DMA and source outputs are combinational from the flags and the control register, so they are sampled at the falling edge right after the control write that changes the enables.

// File: rtl/sff_pkg.sv
// Shared constants, source codes and trigger decode for the serial FIFO
// flag controller. Assumes 2-bit trigger fields and at most 8-bit counts.
package sff_pkg;

    localparam int NFLAG = 6;

    // Flag positions inside the status register (software visible).
    localparam int FL_TXE = 0;
    localparam int FL_RXF = 1;
    localparam int FL_RDY = 2;
    localparam int FL_ERR = 3;
    localparam int FL_BRK = 4;
    localparam int FL_OVR = 5;

    // Register select codes.
    localparam logic [1:0] SEL_STATUS = 2'd0;
    localparam logic [1:0] SEL_CTRL   = 2'd1;
    localparam logic [1:0] SEL_COUNT  = 2'd2;

    // Interrupt source numbers, in falling priority.
    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_ERR  = 3'd1,
        SRC_RXD  = 3'd2,
        SRC_BO   = 3'd3,
        SRC_TX   = 3'd4
    } src_e;

    // Transmit trigger: flag when this many bytes or fewer remain.
    function automatic int tx_trig(input logic [1:0] s);
        case (s)
            2'd0:    return 8;
            2'd1:    return 4;
            2'd2:    return 2;
            default: return 1;
        endcase
    endfunction

    // Receive trigger: flag when at least this many bytes are held.
    function automatic int rx_trig(input logic [1:0] s);
        case (s)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/sff_level_cnt.sv
// Mirrors the fill level of one FIFO from its push and pop strobes.
// Assumes each strobe is one byte per cycle; a push on a full FIFO and a
// pop on an empty one are dropped, judged on the count before the edge.
module sff_level_cnt #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] level
);

    logic push_ok;
    logic pop_ok;

    // Accept strobes only when the FIFO can honour them.
    always_comb begin
        push_ok = push && (level < CW'(DEPTH));
        pop_ok  = pop  && (level != '0);
    end

    // Move the level by the accepted strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (push_ok && !pop_ok) begin
            level <= level + 1'b1;
        end else if (pop_ok && !push_ok) begin
            level <= level - 1'b1;
        end
    end

endmodule

// File: rtl/sff_flag_bank.sv
// Holds the status flags and their read-then-write-zero clearing.
// Assumes set_in is a level condition for bits in LEVEL_MASK (clear wins,
// the flag returns next cycle) and a one-cycle event elsewhere (set wins).
module sff_flag_bank #(
    parameter int            NF         = 6,
    parameter logic [NF-1:0] LEVEL_MASK = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_in,
    input  logic          st_rd,
    input  logic          st_wr,
    input  logic [NF-1:0] wbits,
    output logic [NF-1:0] flags
);

    for (genvar i = 0; i < NF; i++) begin : g_flag
        logic flag_q;
        logic armed_q;
        logic clr;

        assign clr      = st_wr && !wbits[i] && armed_q;
        assign flags[i] = flag_q;

        // Remember that software has seen this flag as 1.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                armed_q <= 1'b0;
            end else if (clr) begin
                armed_q <= 1'b0;
            end else if (st_rd && flag_q) begin
                armed_q <= 1'b1;
            end
        end

        if (LEVEL_MASK[i]) begin : g_level
            // Threshold flag: a clear wins for one cycle, then the level re-sets it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (clr) begin
                    flag_q <= 1'b0;
                end else if (set_in[i]) begin
                    flag_q <= 1'b1;
                end
            end
        end else begin : g_event
            // Event flag: a new event beats a simultaneous clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (set_in[i]) begin
                    flag_q <= 1'b1;
                end else if (clr) begin
                    flag_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/sff_irq_map.sv
// Groups the flags onto four gated interrupt lines, derives the two DMA
// requests from the data lines only, and encodes the top pending source.
// Assumes flag order from sff_pkg and enables ordered err, rxd, bo, tx.
module sff_irq_map
    import sff_pkg::*;
(
    input  logic [NFLAG-1:0] flags,
    input  logic [3:0]       en,
    output logic [3:0]       lines,
    output logic [1:0]       dma,
    output logic [2:0]       src
);

    // Gate each grouped condition by its enable.
    always_comb begin
        lines[0] = en[0] & flags[FL_ERR];
        lines[1] = en[1] & (flags[FL_RXF] | flags[FL_RDY]);
        lines[2] = en[2] & (flags[FL_BRK] | flags[FL_OVR]);
        lines[3] = en[3] & flags[FL_TXE];
    end

    // Only receive data and transmit space may move data by DMA.
    always_comb begin
        dma = {lines[3], lines[1]};
    end

    // Fixed priority: error, receive data, break/overrun, transmit.
    always_comb begin
        if (lines[0])      src = SRC_ERR;
        else if (lines[1]) src = SRC_RXD;
        else if (lines[2]) src = SRC_BO;
        else if (lines[3]) src = SRC_TX;
        else               src = SRC_NONE;
    end

endmodule

// File: rtl/sfifo_flag_ctrl.sv
// Top of the serial FIFO flag and interrupt controller: two level counters,
// the flag bank, the interrupt map and the register decode.
// Assumes the FIFO storage is elsewhere and the strobes match its traffic.
module sfifo_flag_ctrl
    import sff_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_push,
    input  logic        tx_pop,
    input  logic        rx_push,
    input  logic        rx_pop,
    input  logic        rx_err_evt,
    input  logic        rx_brk_evt,
    input  logic        rx_ovr_evt,
    input  logic        rx_idle_evt,
    input  logic [1:0]  reg_sel,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq_err,
    output logic        irq_rxd,
    output logic        irq_bo,
    output logic        irq_tx,
    output logic        dma_rx_req,
    output logic        dma_tx_req,
    output logic [2:0]  irq_src
);

    localparam logic [NFLAG-1:0] LEVEL_FLAGS = NFLAG'((1 << FL_TXE) | (1 << FL_RXF));

    logic [CW-1:0]    tx_lvl;
    logic [CW-1:0]    rx_lvl;
    logic [7:0]       ctrl_q;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] flags;
    logic [3:0]       lines;
    logic [1:0]       dma;
    logic             st_rd;
    logic             st_wr;
    logic             unused_hi;

    assign unused_hi = ^reg_wdata[15:8];

    sff_level_cnt #(.DEPTH(DEPTH), .CW(CW)) u_tx_cnt (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop), .level(tx_lvl)
    );

    sff_level_cnt #(.DEPTH(DEPTH), .CW(CW)) u_rx_cnt (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop), .level(rx_lvl)
    );

    // Control register: trigger selects and interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_wr && reg_sel == SEL_CTRL) begin
            ctrl_q <= reg_wdata[7:0];
        end
    end

    // Status register access strobes.
    always_comb begin
        st_rd = reg_rd && (reg_sel == SEL_STATUS);
        st_wr = reg_wr && (reg_sel == SEL_STATUS);
    end

    // Set conditions: threshold levels and receiver events.
    always_comb begin
        set_vec         = '0;
        set_vec[FL_TXE] = int'(tx_lvl) <= tx_trig(ctrl_q[1:0]);
        set_vec[FL_RXF] = int'(rx_lvl) >= rx_trig(ctrl_q[3:2]);
        set_vec[FL_RDY] = rx_idle_evt && (rx_lvl != '0);
        set_vec[FL_ERR] = rx_err_evt;
        set_vec[FL_BRK] = rx_brk_evt;
        set_vec[FL_OVR] = rx_ovr_evt;
    end

    sff_flag_bank #(.NF(NFLAG), .LEVEL_MASK(LEVEL_FLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_in(set_vec), .st_rd(st_rd),
        .st_wr(st_wr), .wbits(reg_wdata[NFLAG-1:0]), .flags(flags)
    );

    sff_irq_map u_irq (
        .flags(flags), .en(ctrl_q[7:4]), .lines(lines), .dma(dma), .src(irq_src)
    );

    // Drive the named interrupt and DMA outputs.
    always_comb begin
        irq_err    = lines[0];
        irq_rxd    = lines[1];
        irq_bo     = lines[2];
        irq_tx     = lines[3];
        dma_rx_req = dma[0];
        dma_tx_req = dma[1];
    end

    // Read mux over status, control and count registers.
    always_comb begin
        case (reg_sel)
            SEL_STATUS: reg_rdata = 16'(flags);
            SEL_CTRL:   reg_rdata = {8'h00, ctrl_q};
            SEL_COUNT:  reg_rdata = {8'(tx_lvl), 8'(rx_lvl)};
            default:    reg_rdata = 16'h0000;
        endcase
    end

endmodule

// File: rtl/sff_flag_ctrl_chk.sv
// Assertion checker for sfifo_flag_ctrl, attached by bind below.
module sff_flag_ctrl_chk
    import sff_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CW-1:0]    tx_lvl,
    input logic [CW-1:0]    rx_lvl,
    input logic [7:0]       ctrl_q,
    input logic [NFLAG-1:0] flags,
    input logic             rx_err_evt,
    input logic [1:0]       reg_sel,
    input logic             reg_wr,
    input logic [15:0]      reg_wdata,
    input logic             irq_err,
    input logic             irq_tx,
    input logic             dma_rx_req,
    input logic             dma_tx_req,
    input logic [2:0]       irq_src
);

    logic tx_ok;
    logic rx_ok;
    assign tx_ok = int'(tx_lvl) <= tx_trig(ctrl_q[1:0]);
    assign rx_ok = int'(rx_lvl) >= rx_trig(ctrl_q[3:2]);

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_lvl) <= DEPTH) && (int'(rx_lvl) <= DEPTH));

    // R2
    txe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FL_TXE]) |-> $past(tx_ok));

    // R3
    rxf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FL_RXF]) |-> $past(rx_ok));

    // R4
    err_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[FL_ERR]) |-> $past(reg_wr && reg_sel == SEL_STATUS && !reg_wdata[FL_ERR]));

    // R5
    txe_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[FL_TXE] && tx_ok) |=> flags[FL_TXE]);

    // R6
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err_evt |=> flags[FL_ERR]);

    // R7
    irq_tx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> flags[FL_TXE]);

    // R8
    dma_data_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rx_req |-> (flags[FL_RXF] || flags[FL_RDY])) and (dma_tx_req |-> flags[FL_TXE]));

    // R9
    src_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> irq_src == 3'd1);

endmodule

bind sfifo_flag_ctrl sff_flag_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .ctrl_q(ctrl_q),
    .flags(flags), .rx_err_evt(rx_err_evt), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .irq_err(irq_err), .irq_tx(irq_tx),
    .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req), .irq_src(irq_src)
);

// File: tb/sfifo_flag_ctrl_test.sv
module sfifo_flag_ctrl_test;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
    logic        rx_err_evt = 0, rx_brk_evt = 0, rx_ovr_evt = 0, rx_idle_evt = 0;
    logic [1:0]  reg_sel = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        irq_err, irq_rxd, irq_bo, irq_tx, dma_rx_req, dma_tx_req;
    logic [2:0]  irq_src;

    sfifo_flag_ctrl uut (.*);

    int checks = 0, fails = 0;
    int m_tx = 0, m_rx = 0;
    bit done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick; @(negedge clk); endtask

    task automatic drive(input bit tpu, input bit tpo, input bit rpu, input bit rpo);
        int atx, arx;
        atx = ((tpu && m_tx < DEPTH) ? 1 : 0) - ((tpo && m_tx > 0) ? 1 : 0);
        arx = ((rpu && m_rx < DEPTH) ? 1 : 0) - ((rpo && m_rx > 0) ? 1 : 0);
        tx_push = tpu; tx_pop = tpo; rx_push = rpu; rx_pop = rpo;
        tick;
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        m_tx += atx; m_rx += arx;
    endtask

    task automatic pulse(input bit e, input bit b, input bit o, input bit i);
        rx_err_evt = e; rx_brk_evt = b; rx_ovr_evt = o; rx_idle_evt = i;
        tick;
        rx_err_evt = 0; rx_brk_evt = 0; rx_ovr_evt = 0; rx_idle_evt = 0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1;
        tick;
        reg_wr = 0;
    endtask

    task automatic arm;
        reg_sel = 2'd0; reg_rd = 1;
        tick;
        reg_rd = 0;
    endtask

    task automatic peek(input logic [1:0] sel, output logic [15:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic do_reset;
        rst_n = 0; tick; tick;
        m_tx = 0; m_rx = 0;
        rst_n = 1;
    endtask

    function automatic int ttx(input int s);
        return (s == 0) ? 8 : (s == 1) ? 4 : (s == 2) ? 2 : 1;
    endfunction
    function automatic int trx(input int s);
        return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
    endfunction

    task automatic chk_count(input string tag);
        logic [15:0] v;
        peek(2'd2, v);
        chk(tag, v, (m_tx << 8) | m_rx);
    endtask

    // Sweep all 16 enable masks for a known flag vector f (R7, R8, R9).
    task automatic irq_sweep(input int f);
        logic [15:0] v;
        peek(2'd0, v);
        chk("R4 status setup", v, f);
        for (int m = 0; m < 16; m++) begin
            int e_err, e_rxd, e_bo, e_tx, e_src;
            wr(2'd1, 16'(m << 4));
            e_err = (m & 1) && f[3];
            e_rxd = ((m >> 1) & 1) && (f[1] || f[2]);
            e_bo  = ((m >> 2) & 1) && (f[4] || f[5]);
            e_tx  = ((m >> 3) & 1) && f[0];
            e_src = e_err ? 1 : e_rxd ? 2 : e_bo ? 3 : e_tx ? 4 : 0;
            #1;
            chk("R7 irq lines", {irq_tx, irq_bo, irq_rxd, irq_err},
                (e_tx << 3) | (e_bo << 2) | (e_rxd << 1) | e_err);
            chk("R8 dma", {dma_tx_req, dma_rx_req}, (e_tx << 1) | e_rxd);
            chk("R9 source", irq_src, e_src);
        end
        wr(2'd1, 16'h0000);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        // R10: reset state
        tick; tick;
        peek(2'd0, v); chk("R10 status", v, 0);
        peek(2'd1, v); chk("R10 ctrl", v, 0);
        chk_count("R10 count");
        chk("R10 outputs", {irq_err, irq_rxd, irq_bo, irq_tx, dma_rx_req, dma_tx_req, irq_src}, 0);
        rst_n = 1;
        tick; tick;
        peek(2'd0, v); chk("R2 txe after reset", v, 1);

        // R1: counting, saturation, simultaneous strobes
        drive(1, 1, 1, 1); chk_count("R1 push+pop at empty");
        for (int k = 0; k < 18; k++) begin
            drive(1, 0, (k % 2) == 0, 0);
            chk_count("R1 fill");
        end
        drive(1, 1, 0, 0); chk_count("R1 push+pop at full");
        drive(1, 1, 1, 1); chk_count("R1 push+pop mid");
        for (int k = 0; k < 18; k++) begin
            drive(0, 1, 0, 1);
            chk_count("R1 drain");
        end

        // R2, R4, R5: transmit threshold sweep for every trigger select
        for (int s = 0; s < 4; s++) begin
            wr(2'd1, 16'(s));
            while (m_tx > 0) drive(0, 1, 0, 0);
            for (int lvl = 0; lvl <= DEPTH; lvl++) begin
                if (lvl > 0) drive(1, 0, 0, 0);
                tick;
                arm;
                wr(2'd0, 16'hFFFE);
                peek(2'd0, v); chk("R4 txe cleared", v[0], 0);
                tick;
                peek(2'd0, v); chk("R2 R5 txe vs trigger", v[0], (lvl <= ttx(s)) ? 1 : 0);
            end
        end

        // R3, R4, R5: receive threshold sweep
        for (int s = 0; s < 4; s++) begin
            wr(2'd1, 16'(s << 2));
            while (m_rx > 0) drive(0, 0, 0, 1);
            for (int lvl = 0; lvl <= DEPTH; lvl++) begin
                if (lvl > 0) drive(0, 0, 1, 0);
                tick;
                arm;
                wr(2'd0, 16'hFFFD);
                peek(2'd0, v); chk("R4 rxf cleared", v[1], 0);
                tick;
                peek(2'd0, v); chk("R3 R5 rxf vs trigger", v[1], (lvl >= trx(s)) ? 1 : 0);
            end
        end
        wr(2'd1, 16'h0000);

        // R6 and R4: event flags and clearing protocol
        while (m_rx > 0) drive(0, 0, 0, 1);
        pulse(0, 0, 0, 1);
        peek(2'd0, v); chk("R6 idle ignored when empty", v[2], 0);
        drive(0, 0, 1, 0);
        pulse(0, 0, 0, 1);
        peek(2'd0, v); chk("R6 idle sets ready", v[2], 1);
        pulse(1, 0, 0, 0);
        peek(2'd0, v); chk("R6 error sets", v[3], 1);
        wr(2'd0, 16'hFFF7);
        peek(2'd0, v); chk("R4 zero without read kept", v[3], 1);
        arm;
        wr(2'd0, 16'hFFFF);
        peek(2'd0, v); chk("R4 writing one kept", v[3], 1);
        wr(2'd0, 16'hFFF7);
        peek(2'd0, v); chk("R4 read then zero clears", v[3], 0);
        pulse(0, 1, 1, 0);
        peek(2'd0, v); chk("R6 break and overrun set", v[5:4], 3);
        pulse(1, 0, 0, 0);
        arm;
        rx_err_evt = 1; reg_sel = 2'd0; reg_wdata = 16'hFFF7; reg_wr = 1;
        tick;
        rx_err_evt = 0; reg_wr = 0;
        peek(2'd0, v); chk("R6 event beats clear", v[3], 1);
        arm;
        wr(2'd0, 16'hFFF7);
        peek(2'd0, v); chk("R4 clear after re-read", v[3], 0);

        // R7, R8, R9: interrupt grouping, DMA and priority
        do_reset;
        tick;
        drive(0, 0, 1, 0);
        pulse(1, 1, 0, 0);
        tick;
        irq_sweep(6'h1B);
        arm;
        wr(2'd0, 16'hFFE7);
        irq_sweep(6'h03);
        for (int k = 0; k < DEPTH; k++) drive(1, 0, 0, 0);
        arm;
        wr(2'd0, 16'hFFFE);
        drive(0, 0, 0, 1);
        arm;
        wr(2'd0, 16'hFFFD);
        pulse(0, 0, 1, 0);
        tick;
        irq_sweep(6'h20);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule